// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a long serial register that sits between the chip's pads and its core logic. Each position in the chain is typed. Input cells sit between a pad and the core input it feeds. Output cells sit between a core output and the pad that drives it. A test access controller, which is outside this block, supplies a test clock, the capture, shift and update strobes of the data-register path, and a three-bit mode code. The chain shifts serially from `tdi` toward `tdo`.

For each pad and each core signal, the block decides whether the functional value or the value held in the cell's update latch goes through. In external test, the pads are driven from the latches and the pad levels are captured. In internal test, the core inputs are driven from the latches and the core outputs are captured. Sample/preload takes a snapshot without disturbing anything. Clamp holds the pads at the latched values while the chain stays idle. High-impedance releases every pad driver.

The cell count is set by two parameters, `N_IN` and `N_OUT`, which default to 242 each for 484 cells. The serial port is a plain level interface with no handshake. One bit moves per test clock while `shift_dr` is high.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, every capture/shift stage and every update latch clears to 0. After reset, `tdo` reads 0 until a capture or shift happens.
- R2: In functional mode (code 0, and also unused codes 6 and 7), `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pin_in`. Capture, shift and update strobes have no effect, so the update latches keep their contents.
- R3: Cell 0 is nearest `tdo`. Cells 0..N_IN-1 are input cells, bit k matching `pin_in[k]`/`core_in[k]`. Cells N_IN..N_IN+N_OUT-1 are output cells, cell N_IN+j matching `core_out[j]`/`pad_out[j]`. Each clock with `shift_dr` high moves every cell one place toward `tdo`, and `tdi` enters the last cell. `tdo` always shows cell 0.
- R4: In external test (code 1), a capture loads each input cell with `pin_in` and each output cell with its own update latch value.
- R5: In external test, `pad_out` shows the output cells' update latches and `pad_oe` is all ones. The latches, and so the pads, change only on a clock with `update_dr` high, which copies the shifted vector into them.
- R6: In internal test (code 2), a capture loads each output cell with `core_out` and each input cell with its update latch. `core_in` shows the input latches, which change only at update, and is not affected by `pin_in`.
- R7: In sample/preload (code 3), a capture loads input cells with `pin_in` and output cells with `core_out`, and all functional paths stay as in R2. An update in this mode preloads the latches, and external test then drives them onto the pads.
- R8: In clamp (code 4), `pad_out` shows the output latches and `pad_oe` is all ones, while capture, shift and update strobes leave the chain and the latches unchanged.
- R9: In high-impedance (code 5), `pad_oe` is all zeros and `core_in` equals `pin_in`. Strobes leave the latches unchanged.
- R10: When `capture_dr` and `shift_dr` are both high in a chain mode, capture wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Mode code: 0 functional, 1 external test, 2 internal test, 3 sample/preload, 4 clamp, 5 high-impedance |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in, enters the last cell |
| tdo | output | 1 | Serial data out, shows cell 0 |
| pin_in | input | N_IN | Levels arriving from input pads |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Functional values from the core outputs |
| core_oe | input | N_OUT | Functional output enables from the core |
| pad_out | output | N_OUT | Values sent to the output pad drivers |
| pad_oe | output | N_OUT | Enables sent to the output pad drivers |

## Verification
The mux outputs `pad_out`, `pad_oe` and `core_in` are combinational, so the bench checks them in the same cycle that inputs or mode change, a few nanoseconds after the negative edge. A capture or shift edge shows on `tdo` by the following negative edge, where the bench reads each serial bit before driving the next `tdi`. An update edge moves the latches onto the pads or the core inputs, and the bench checks them at the negative edge after that update. It also checks them once more after all shifting is done and before the update, to confirm that they did not move early.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [2:0] {
    BS_FUNC   = 3'd0,
    BS_EXTEST = 3'd1,
    BS_INTEST = 3'd2,
    BS_SAMPLE = 3'd3,
    BS_CLAMP  = 3'd4,
    BS_HIGHZ  = 3'd5
  } bs_mode_e;
endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
  import bscan_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       capture_dr,
  input  logic       shift_dr,
  input  logic       update_dr,
  output logic       cap_en,
  output logic       shift_en,
  output logic       upd_en,
  output logic       out_test,
  output logic       in_test,
  output logic       oe_on,
  output logic       oe_off
);
  bs_mode_e m;
  logic     chain_act;

  always_comb begin
    m         = bs_mode_e'(mode);
    chain_act = 1'b0;
    out_test  = 1'b0;
    in_test   = 1'b0;
    oe_on     = 1'b0;
    oe_off    = 1'b0;
    unique case (mode)
      BS_EXTEST: begin chain_act = 1'b1; out_test = 1'b1; oe_on = 1'b1; end
      BS_INTEST: begin chain_act = 1'b1; in_test = 1'b1; end
      BS_SAMPLE: chain_act = 1'b1;
      BS_CLAMP:  begin out_test = 1'b1; oe_on = 1'b1; end
      BS_HIGHZ:  begin out_test = 1'b1; oe_off = 1'b1; end
      default:   chain_act = 1'b0;
    endcase
    // capture has priority over shift (R10)
    cap_en   = chain_act & capture_dr;
    shift_en = chain_act & shift_dr & ~capture_dr;
    upd_en   = chain_act & update_dr;
  end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic drive_test,
  input  logic scan_in,
  input  logic func_in,
  output logic scan_q,
  output logic data_out
);
  logic sr_q;
  logic upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= 1'b0;
    else if (cap_en)   sr_q <= drive_test ? upd_q : func_in;
    else if (shift_en) sr_q <= scan_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_q <= 1'b0;
    else if (upd_en) upd_q <= sr_q;
  end

  assign scan_q   = sr_q;
  assign data_out = drive_test ? upd_q : func_in;

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (sr_q == $past(scan_in))) else $error("shift"); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upd_q)) else $error("latch"); // R5
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 242,
  parameter int N_OUT = 242
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int N_CELLS = N_IN + N_OUT;

  logic cap_en, shift_en, upd_en, out_test, in_test, oe_on, oe_off;
  logic [N_CELLS:0] chain;

  bscan_mode_dec u_dec (
    .mode(mode), .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
    .out_test(out_test), .in_test(in_test), .oe_on(oe_on), .oe_off(oe_off)
  );

  assign chain[N_CELLS] = tdi;
  assign tdo            = chain[0];

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    if (i < N_IN) begin : g_in
      bscan_cell u_cell (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .drive_test(in_test), .scan_in(chain[i+1]), .func_in(pin_in[i]),
        .scan_q(chain[i]), .data_out(core_in[i])
      );
    end else begin : g_out
      bscan_cell u_cell (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .drive_test(out_test), .scan_in(chain[i+1]), .func_in(core_out[i-N_IN]),
        .scan_q(chain[i]), .data_out(pad_out[i-N_IN])
      );
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_oe
    assign pad_oe[j] = oe_off ? 1'b0 : (oe_on ? 1'b1 : core_oe[j]);
  end

  AST_HIGHZ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BS_HIGHZ) |-> (pad_oe == '0)) else $error("highz"); // R9
  AST_TEST_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BS_EXTEST || mode == BS_CLAMP) |-> (&pad_oe)) else $error("oe"); // R5
  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BS_FUNC) |-> (pad_out == core_out && core_in == pin_in && pad_oe == core_oe))
    else $error("func"); // R2
  AST_PADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BS_CLAMP && $past(mode) == BS_CLAMP) |-> $stable(pad_out)) else $error("clamp"); // R8
  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BS_INTEST && $past(mode) == BS_INTEST && !$past(update_dr)) |-> $stable(core_in))
    else $error("intest"); // R6
endmodule

// File: tb/bscan_chain_bench.sv
`timescale 1ns/1ps
module bscan_chain_bench;
  localparam int NI = 3;
  localparam int NO = 3;
  localparam int NC = NI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] core_oe = '0;
  logic [NO-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [NC-1:0] lat = '0;   // bench model of the update latches

  always #10 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) u_bscan_chain (
    .clk(clk), .rst_n(rst_n), .mode(mode), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic cap_shift(input bit do_cap, input logic [NC-1:0] load, output logic [NC-1:0] got);
    if (do_cap) begin
      capture_dr = 1'b1; @(negedge clk); capture_dr = 1'b0;
    end
    shift_dr = 1'b1;
    for (int i = 0; i < NC; i++) begin
      got[i] = tdo; tdi = load[i]; @(negedge clk);
    end
    shift_dr = 1'b0;
  endtask

  task automatic upd();
    update_dr = 1'b1; @(negedge clk); update_dr = 1'b0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NC-1:0] got, load;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tdo in reset", tdo, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tdo after reset", tdo, 0);
    mode = 3'd1; #1;
    chk("R1 latches clear", pad_out, 0);
    mode = 3'd0; #1;

    // R2 functional pass-through, exhaustive over small vectors
    for (int k = 0; k < 64; k++) begin
      pin_in = k[2:0]; core_out = k[5:3]; core_oe = k[2:0] ^ 3'b101; #1;
      chk("R2 pad_out", pad_out, k[5:3]);
      chk("R2 pad_oe", pad_oe, k[2:0] ^ 3'b101);
      chk("R2 core_in", core_in, k[2:0]);
    end
    for (int c = 6; c < 8; c++) begin
      mode = c[2:0]; core_out = 3'b110; #1;
      chk("R2 unused code", pad_out, 3'b110);
    end
    // R2 strobes ignored in functional mode
    mode = 3'd0; @(negedge clk);
    cap_shift(1'b1, 6'b111111, got); upd();
    chk("R2 tdo untouched", tdo, 0);
    mode = 3'd1; #1;
    chk("R2 latches untouched", pad_out, 0);

    // R7 sample/preload, R3 order
    mode = 3'd3; pin_in = 3'b011; core_out = 3'b100; core_oe = 3'b010; @(negedge clk);
    cap_shift(1'b1, 6'b101101, got);
    chk("R7 capture pins and core", got, {3'b100, 3'b011});
    chk("R7 functional pad_out", pad_out, 3'b100);
    chk("R7 functional core_in", core_in, 3'b011);
    // R3 shift-only: loaded vector comes back in cell order
    cap_shift(1'b0, 6'b010011, got);
    chk("R3 serial order", got, 6'b101101);
    upd(); lat = 6'b010011;
    chk("R7 pad_oe unchanged", pad_oe, 3'b010);
    mode = 3'd1; #1;
    chk("R7 preload drives pads", pad_out, lat[5:3]);

    // R4 R5 external test sweep
    for (int k = 0; k < 64; k++) begin
      load = 6'((k * 37 + 5) & 63);
      pin_in = k[2:0]; core_out = ~k[2:0]; @(negedge clk);
      cap_shift(1'b1, load, got);
      chk("R4 input cells capture pins", got[2:0], k[2:0]);
      chk("R4 output cells capture latches", got[5:3], lat[5:3]);
      chk("R5 pads hold before update", pad_out, lat[5:3]);
      upd(); lat = load;
      chk("R5 pads after update", pad_out, load[5:3]);
      chk("R5 oe forced", pad_oe, 3'b111);
    end

    // R10 capture wins over shift
    pin_in = 3'b101; @(negedge clk);
    capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b0; @(negedge clk);
    capture_dr = 1'b0; shift_dr = 1'b0;
    chk("R10 capture priority", tdo, 1);

    // R6 internal test sweep
    mode = 3'd2; @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      load = 6'((k * 11 + 3) & 63);
      core_out = k[2:0]; pin_in = k[5:3]; @(negedge clk);
      cap_shift(1'b1, load, got);
      chk("R6 output cells capture core", got[5:3], k[2:0]);
      chk("R6 input cells capture latches", got[2:0], lat[2:0]);
      chk("R6 core_in holds before update", core_in, lat[2:0]);
      upd(); lat = load;
      chk("R6 core_in after update", core_in, load[2:0]);
      pin_in = ~pin_in; #1;
      chk("R6 pins ignored", core_in, load[2:0]);
    end

    // R8 clamp
    mode = 3'd4; core_out = ~lat[5:3]; core_oe = 3'b000; @(negedge clk);
    chk("R8 clamp pads", pad_out, lat[5:3]);
    chk("R8 clamp oe", pad_oe, 3'b111);
    cap_shift(1'b1, ~lat, got); upd();
    chk("R8 strobes ignored", pad_out, lat[5:3]);

    // R9 high-impedance
    mode = 3'd5; core_oe = 3'b111; pin_in = 3'b110; @(negedge clk);
    chk("R9 oe released", pad_oe, 3'b000);
    chk("R9 core_in functional", core_in, 3'b110);
    cap_shift(1'b1, ~lat, got); upd();
    mode = 3'd1; #1;
    chk("R9 strobes ignored", pad_out, lat[5:3]);

    finish_run();
  end
endmodule